// File: doc/BRIEF.md
# Read Strobe Delay Calibration Controller

This block tunes the read-capture delays of a double-data-rate memory interface after reset. When started, it returns the strobe and data delay lines to tap zero and then advances both by a programmable start offset. The offset accounts for a fixed clock-buffer delay that shifts the initial data-to-strobe alignment. Next it steps the strobe delay one tap at a time. After each step it waits a settle interval, then samples the delayed strobe with the internal clock and looks for changes of level.

The tap distance between two found edges is taken as the measured period. The strobe is left at the second edge, and the data line is placed a quarter of that distance beyond it. If the delay range runs out after only one edge, as happens at low clock rates, the block does not give up. It moves both lines a fixed safe gap away from that edge and reports success. If no edge appears anywhere in the range, it stops at the top tap and reports failure.

A manual mode skips the search and loads two fixed tap values. The delay lines are driven only by one-tap increment pulses and reset pulses, so the block tracks each tap position itself.

Top module: `rd_strobe_cal`

## Requirements
- R1: During and right after reset, `done`, `fail`, `stb_inc`, `stb_rst`, `dat_inc` and `dat_rst` are all 0.
- R2: A `start` pulse with `man_en`=0 clears `done` and `fail` in the next cycle. It then pulses `stb_rst` and `dat_rst` together for one cycle and advances both lines by `init_ofs` taps before the first strobe sample is taken.
- R3: After every strobe tap change the block waits `SETTLE` cycles (default 8). A level counts only once `AGREE` (default 4) consecutive samples are equal. Isolated single-cycle glitches on `stb_smp` do not change the result.
- R4: The reference level is the one seen at tap `init_ofs`. The first edge e1 is the first tap whose level differs from it. The second edge e2 is the next tap whose level differs from the level at e1. With two edges, the final strobe tap is e2 and the final data tap is min(e2 + ((e2-e1)>>2), 63). `done` is then 1.
- R5: If tap 63 is reached after exactly one edge e1, both lines end at e1-16 when e1>=32 and at e1+16 otherwise. `done` is then 1 and `fail` is 0.
- R6: If no edge is found up to tap 63, `fail` is 1 and `done` is 0. The strobe line stays at tap 63 and the data line stays at `init_ofs`.
- R7: No increment pulse is ever issued to a line that is already at tap 63.
- R8: A `start` with `man_en`=1 resets both lines and advances them to `man_stb_tap` and `man_dat_tap` without sampling the strobe. `done` is then 1.
- R9: `done` and `fail` are never 1 together. No delay-line pulse is issued while either is set, and both hold until the next `start`.
- R10: On each line, an increment pulse and a reset pulse never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to calibrate or load manual taps |
| stb_smp | input | 1 | Delayed strobe as sampled by the internal clock |
| init_ofs | input | 6 | Start tap for both lines before the sweep |
| man_en | input | 1 | Selects manual loading instead of calibration |
| man_stb_tap | input | 6 | Fixed strobe tap for manual mode |
| man_dat_tap | input | 6 | Fixed data tap for manual mode |
| stb_inc | output | 1 | One-tap increment pulse to the strobe delay line |
| stb_rst | output | 1 | Return-to-zero pulse to the strobe delay line |
| dat_inc | output | 1 | One-tap increment pulse to the data delay line |
| dat_rst | output | 1 | Return-to-zero pulse to the data delay line |
| done | output | 1 | Calibration or manual load finished successfully |
| fail | output | 1 | No strobe edge found in the delay range |

## Verification
The checker watches every cycle for the following: `done` and `fail` never both set, increment and reset never together on one line, and no line stepped past tap 63. It follows each line's position from the pulses alone. It also confirms that the lines stay quiet while a result is held. The final tap positions cannot be judged cycle by cycle: the two-edge quarter placement and its clamp, the single-edge gap, the manual load and the start offset. Neither can the glitch filter's effect. These come only from the bench's scenarios, where a model delay line turns a chosen strobe phase and period into edges, and the settled taps are compared with computed values.

// File: rtl/rd_strobe_cal.sv
module rd_strobe_cal #(
  parameter int TAP_W    = 6,
  parameter int SETTLE   = 8,
  parameter int AGREE    = 4,
  parameter int SAFE_GAP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stb_smp,
  input  logic [TAP_W-1:0] init_ofs,
  input  logic             man_en,
  input  logic [TAP_W-1:0] man_stb_tap,
  input  logic [TAP_W-1:0] man_dat_tap,
  output logic             stb_inc,
  output logic             stb_rst,
  output logic             dat_inc,
  output logic             dat_rst,
  output logic             done,
  output logic             fail
);
  localparam int SW = $clog2(SETTLE + 1);
  localparam int AW = $clog2(AGREE + 1);
  localparam logic [TAP_W-1:0] MAXT = '1;
  localparam logic [TAP_W-1:0] HALF = MAXT >> 1;
  localparam logic [TAP_W-1:0] GAP  = TAP_W'(SAFE_GAP);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_WALK, S_SETTLE, S_SAMP, S_STEP, S_DONE, S_FAIL} st_t;
  st_t st;

  logic             fin, have_ref, level, last_smp, got_one;
  logic [TAP_W-1:0] stb_tap, dat_tap, stb_tgt, dat_tgt, e1;
  logic [SW-1:0]    wait_cnt;
  logic [AW-1:0]    run_cnt, run_nx;
  logic             hit, edge_now;
  logic [TAP_W-1:0] qtr, dat_fit, one_e, fb_tap;
  logic [TAP_W:0]   sum;

  assign run_nx   = (run_cnt != '0 && stb_smp != last_smp) ? AW'(1) : run_cnt + AW'(1);
  assign hit      = (run_nx == AW'(AGREE));
  assign edge_now = hit && have_ref && (stb_smp != level);
  assign qtr      = (stb_tap - e1) >> 2;
  assign sum      = {1'b0, stb_tap} + {1'b0, qtr};
  assign dat_fit  = sum[TAP_W] ? MAXT : sum[TAP_W-1:0];
  assign one_e    = got_one ? e1 : stb_tap;
  assign fb_tap   = (one_e > HALF) ? one_e - GAP : one_e + GAP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; fin <= 1'b0; have_ref <= 1'b0; level <= 1'b0; last_smp <= 1'b0;
      got_one <= 1'b0; stb_tap <= '0; dat_tap <= '0; stb_tgt <= '0; dat_tgt <= '0;
      e1 <= '0; wait_cnt <= '0; run_cnt <= '0;
      stb_inc <= 1'b0; stb_rst <= 1'b0; dat_inc <= 1'b0; dat_rst <= 1'b0;
      done <= 1'b0; fail <= 1'b0;
    end else begin
      stb_inc <= 1'b0; stb_rst <= 1'b0; dat_inc <= 1'b0; dat_rst <= 1'b0;
      case (st)
        S_IDLE, S_DONE, S_FAIL: if (start) begin
          done <= 1'b0; fail <= 1'b0;
          fin <= man_en; have_ref <= 1'b0; got_one <= 1'b0;
          stb_tgt <= man_en ? man_stb_tap : init_ofs;
          dat_tgt <= man_en ? man_dat_tap : init_ofs;
          st <= S_RST;
        end
        S_RST: begin
          stb_rst <= 1'b1; dat_rst <= 1'b1;
          stb_tap <= '0; dat_tap <= '0;
          st <= S_WALK;
        end
        S_WALK: begin
          if (stb_tap < stb_tgt) begin stb_inc <= 1'b1; stb_tap <= stb_tap + TAP_W'(1); end
          if (dat_tap < dat_tgt) begin dat_inc <= 1'b1; dat_tap <= dat_tap + TAP_W'(1); end
          if (stb_tap == stb_tgt && dat_tap == dat_tgt) begin
            if (fin) begin done <= 1'b1; st <= S_DONE; end
            else begin wait_cnt <= '0; st <= S_SETTLE; end
          end
        end
        S_SETTLE: begin
          wait_cnt <= wait_cnt + SW'(1);
          if (wait_cnt == SW'(SETTLE - 1)) begin run_cnt <= '0; st <= S_SAMP; end
        end
        S_SAMP: begin
          run_cnt  <= run_nx;
          last_smp <= stb_smp;
          if (hit) begin
            level <= stb_smp; have_ref <= 1'b1;
            if (edge_now && !got_one) begin e1 <= stb_tap; got_one <= 1'b1; end
            if (edge_now && got_one) begin
              stb_tgt <= stb_tap; dat_tgt <= dat_fit; fin <= 1'b1; st <= S_RST;
            end else if (stb_tap == MAXT) begin
              if (!got_one && !edge_now) begin fail <= 1'b1; st <= S_FAIL; end
              else begin stb_tgt <= fb_tap; dat_tgt <= fb_tap; fin <= 1'b1; st <= S_RST; end
            end else st <= S_STEP;
          end
        end
        S_STEP: begin
          stb_inc <= 1'b1; stb_tap <= stb_tap + TAP_W'(1);
          wait_cnt <= '0; st <= S_SETTLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rd_strobe_cal_chk #(parameter int TAP_W = 6) (
  input logic clk, rst_n, stb_inc, stb_rst, dat_inc, dat_rst, done, fail
);
  localparam logic [TAP_W-1:0] MAXT = '1;
  logic [TAP_W-1:0] s_pos, d_pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin s_pos <= '0; d_pos <= '0; end
    else begin
      if (stb_rst) s_pos <= '0; else if (stb_inc) s_pos <= s_pos + TAP_W'(1);
      if (dat_rst) d_pos <= '0; else if (dat_inc) d_pos <= d_pos + TAP_W'(1);
    end
  end

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && fail)); // R9
  AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (done || fail) |-> !(stb_inc || stb_rst || dat_inc || dat_rst)); // R9
  AST_STB_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(stb_inc && stb_rst)); // R10
  AST_DAT_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(dat_inc && dat_rst)); // R10
  AST_STB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) stb_inc |-> s_pos != MAXT); // R7
  AST_DAT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) dat_inc |-> d_pos != MAXT); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $past(done) && !done |-> !fail); // R9
endmodule

bind rd_strobe_cal rd_strobe_cal_chk #(.TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb_inc(stb_inc), .stb_rst(stb_rst),
  .dat_inc(dat_inc), .dat_rst(dat_rst), .done(done), .fail(fail)
);

// File: tb/sim_rd_strobe_cal.sv
module sim_rd_strobe_cal;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, man_en = 1'b0;
  logic [5:0] init_ofs = '0, man_stb_tap = '0, man_dat_tap = '0;
  logic stb_smp, stb_inc, stb_rst, dat_inc, dat_rst, done, fail;
  int checks = 0, failures = 0;
  int m_stb = 0, m_dat = 0, ph = 0, hp = 12;
  logic noise_en = 1'b0, glitch = 1'b0;

  always #10 clk = ~clk;

  rd_strobe_cal u0 (.clk(clk), .rst_n(rst_n), .start(start), .stb_smp(stb_smp),
    .init_ofs(init_ofs), .man_en(man_en), .man_stb_tap(man_stb_tap), .man_dat_tap(man_dat_tap),
    .stb_inc(stb_inc), .stb_rst(stb_rst), .dat_inc(dat_inc), .dat_rst(dat_rst),
    .done(done), .fail(fail));

  function automatic logic lvl(int t, int p, int h);
    return logic'(((t + p) / h) % 2);
  endfunction

  always @(posedge clk) begin
    if (stb_rst) m_stb <= 0; else if (stb_inc) m_stb <= m_stb + 1;
    if (dat_rst) m_dat <= 0; else if (dat_inc) m_dat <= m_dat + 1;
  end
  always @(negedge clk) glitch <= noise_en && !glitch && ($urandom % 16 == 0);
  assign stb_smp = lvl(m_stb, ph, hp) ^ glitch;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin failures++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic expect_cal(int ofs, int p, int h, output int es, output int ed, output int ok);
    int e1 = -1, e2 = -1;
    logic cur = lvl(ofs, p, h);
    for (int t = ofs + 1; t <= 63; t++) begin
      if (lvl(t, p, h) != cur) begin
        cur = lvl(t, p, h);
        if (e1 < 0) e1 = t; else begin e2 = t; break; end
      end
    end
    if (e2 >= 0) begin es = e2; ed = (e2 + ((e2 - e1) >> 2) > 63) ? 63 : e2 + ((e2 - e1) >> 2); ok = 1; end
    else if (e1 >= 0) begin es = (e1 >= 32) ? e1 - 16 : e1 + 16; ed = es; ok = 1; end
    else begin es = 63; ed = ofs; ok = 0; end
  endtask

  task automatic run(bit man, int ofs, int p, int h, int ms, int md, string req);
    int es, ed, ok, n;
    @(negedge clk);
    man_en = man; init_ofs = 6'(ofs); man_stb_tap = 6'(ms); man_dat_tap = 6'(md); ph = p; hp = h;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R2 result cleared", {30'd0, done, fail}, 0);
    n = 0;
    while (!done && !fail && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk("R3 run timeout", 1, 0);
    if (man) begin es = ms; ed = md; ok = 1; end
    else expect_cal(ofs, p, h, es, ed, ok);
    chk({req, " done"}, int'(done), ok);
    chk({req, " fail"}, int'(fail), 1 - ok);
    chk({req, " strobe tap"}, m_stb, es);
    chk({req, " data tap"}, m_dat, ed);
    repeat (3) @(negedge clk);
    chk("R9 result held", {30'd0, done, fail}, ok ? 2 : 1);
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R1 done", int'(done), 0); chk("R1 fail", int'(fail), 0);
    chk("R1 pulses", {28'd0, stb_inc, stb_rst, dat_inc, dat_rst}, 0);
    rst_n = 1'b1; @(negedge clk);
    chk("R1 after reset", {28'd0, stb_inc, stb_rst, done, fail}, 0);
    run(0, 0, 0, 12, 0, 0, "R4 basic");
    run(0, 5, 3, 10, 0, 0, "R4 offset R2");
    run(0, 30, 0, 20, 0, 0, "R4 clamp");
    run(0, 0, 0, 40, 0, 0, "R5 high edge");
    run(0, 0, 40, 50, 0, 0, "R5 low edge");
    run(0, 0, 1, 64, 0, 0, "R5 edge at top R7");
    run(0, 7, 0, 1000, 0, 0, "R6 no edge R2");
    run(1, 9, 0, 12, 17, 42, "R8 manual");
    run(1, 0, 0, 12, 63, 0, "R8 manual max");
    noise_en = 1'b1;
    run(0, 0, 0, 12, 0, 0, "R3 glitch");
    run(0, 3, 2, 9, 0, 0, "R3 glitch");
    for (int i = 0; i < 20; i++) begin
      int h = 4 + int'($urandom % 60);
      noise_en = logic'($urandom % 2);
      run(0, int'($urandom % 12), int'($urandom % 32'(h)), h, 0, 0, "R4 random");
    end
    noise_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL R3 watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule